// File: doc/BRIEF.md
# Steered-Operand Arithmetic Logic Unit

This block combines two operand words with one of a small set of arithmetic or bitwise functions. A 4-bit function code and a carry input choose the function. The word width is a parameter and defaults to 4 bits.

All arithmetic goes through a single ripple adder. Its first input is always operand A. Its second input is chosen by the low two code bits from four candidates: zero, B, the ones' complement of B, or all ones. The carry input is added at the least significant bit. From these choices come pass-through, increment, add, add with carry, subtract with borrow, two's-complement subtract, decrement, and a wrap back to A.

When the top code bit is set, a bitwise unit replaces the adder. The carry input then has no effect. The result and the carry out are registered, so they appear one clock edge after the inputs are sampled.

Top module: `alu_mode_top`

## Requirements
- R1: A synchronous active-high `rst` clears `result` and `carry_out` to 0 at the next rising edge of `clk`. Any earlier values are discarded.
- R2: Outside reset, `result` and `carry_out` take the values computed from `op_a`, `op_b`, `sel` and `carry_in` as sampled at the previous rising edge. The latency is exactly one cycle.
- R3: With `sel`=4'b0000, the block adds a zero operand. When `carry_in`=0, `result`=A and `carry_out`=0. When `carry_in`=1, `result`=A+1 modulo 2^WIDTH, and `carry_out`=1 only when A is all ones.
- R4: With `sel`=4'b0001, `result`=(A+B+`carry_in`) modulo 2^WIDTH. `carry_out` is the carry out of the most significant bit.
- R5: With `sel`=4'b0010, the block computes A + ~B + `carry_in`. When `carry_in`=1, `result`=A−B in two's complement and `carry_out`=1 exactly when A≥B unsigned. When `carry_in`=0, `result`=A−B−1.
- R6: With `sel`=4'b0011, the block adds an all-ones operand. When `carry_in`=0, `result`=A−1 and `carry_out`=1 unless A=0. When `carry_in`=1, `result`=A and `carry_out`=1.
- R7: While `sel[3]`=0, `sel[2]` has no effect. Codes 4'b01xx give the same result and carry as 4'b00xx.
- R8: While `sel[3]`=1, `sel[1:0]` chooses a bitwise function: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOT A. In this group `sel[2]` and `carry_in` are ignored, and `carry_out` is 0.
- R9: Every function above holds at any `WIDTH`. Both the 4-bit default and an 8-bit build behave as stated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand, always the adder's first input |
| op_b | input | WIDTH | Second operand, steered before the adder |
| sel | input | 4 | Function code: bit 3 picks the group, bits 1:0 pick the function |
| carry_in | input | 1 | Carry into the adder's least significant bit |
| result | output | WIDTH | Registered function result |
| carry_out | output | 1 | Registered adder carry out; 0 in the bitwise group |

## Verification
Each result is due on the rising edge that follows the inputs. There is exactly one register stage between the input pins and the output pins. The bench drives a new vector on a falling edge and lets one rising edge capture it. It compares both outputs on the next falling edge, so every comparison lands half a cycle after the only edge that could change them. Reset clearing is checked the same way: one edge after `rst` rises while the outputs hold non-zero values.

// File: rtl/alu_mode_pkg.sv
package alu_mode_pkg;

  // Second adder operand picked by sel[1:0] in the arithmetic group
  typedef enum logic [1:0] {
    ARG_ZERO = 2'b00,
    ARG_B    = 2'b01,
    ARG_NB   = 2'b10,
    ARG_ONES = 2'b11
  } arg_pick_e;

  // Bitwise function picked by sel[1:0] in the logic group
  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_NOTA = 2'b11
  } logic_fn_e;

  localparam int SEL_W     = 4;
  localparam int GROUP_BIT = 3;

endpackage

// File: rtl/alu_operand_steer.sv
module alu_operand_steer
  import alu_mode_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [1:0]       pick,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] arg_out
);

  always_comb begin
    unique case (arg_pick_e'(pick))
      ARG_ZERO: arg_out = '0;
      ARG_B:    arg_out = b_in;
      ARG_NB:   arg_out = ~b_in;
      ARG_ONES: arg_out = '1;
      default:  arg_out = '0;
    endcase
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] s,
  output logic             co
);

  logic [WIDTH:0] chain;

  assign chain[0] = ci;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign s[i]       = a[i] ^ b[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
  end

  assign co = chain[WIDTH];

  // R4: the bit-level chain must agree with whole-word addition
  always_comb begin
    if (!$isunknown({a, b, ci})) begin
      a_r4_chain_sum: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci}))
        else $error("a_r4_chain_sum: ripple chain disagrees with word sum");
    end
  end

endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit
  import alu_mode_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [1:0]       fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (logic_fn_e'(fn))
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_NOTA: y = ~a;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_mode_top.sv
module alu_mode_top
  import alu_mode_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [SEL_W-1:0] sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  logic [WIDTH-1:0] steered_arg;
  logic [WIDTH-1:0] adder_sum;
  logic             adder_co;
  logic [WIDTH-1:0] bitwise_y;
  logic [WIDTH-1:0] next_result;
  logic             next_carry;
  logic             is_logic;

  assign is_logic = sel[GROUP_BIT];

  // sel[2] reaches no unit: it is ignored in both groups
  alu_operand_steer #(.WIDTH(WIDTH)) u_steer (
    .pick    (sel[1:0]),
    .b_in    (op_b),
    .arg_out (steered_arg)
  );

  alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .a  (op_a),
    .b  (steered_arg),
    .ci (carry_in),
    .s  (adder_sum),
    .co (adder_co)
  );

  alu_bitwise_unit #(.WIDTH(WIDTH)) u_bitwise (
    .fn (sel[1:0]),
    .a  (op_a),
    .b  (op_b),
    .y  (bitwise_y)
  );

  always_comb begin
    if (is_logic) begin
      next_result = bitwise_y;
      next_carry  = 1'b0;
    end else begin
      next_result = adder_sum;
      next_carry  = adder_co;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= next_result;
      carry_out <= next_carry;
    end
  end

  // R8: the bitwise group never reports a carry
  a_r8_logic_no_carry: assert property (@(posedge clk) disable iff (rst)
    sel[GROUP_BIT] |=> (carry_out == 1'b0));

  // R3: code 0000 without carry passes A through
  a_r3_pass_through: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'b0000 && !carry_in) |=> (result == $past(op_a) && !carry_out));

  // R6: all-ones operand plus carry wraps back to A with carry set
  a_r6_wrap_to_a: assert property (@(posedge clk) disable iff (rst)
    (sel[GROUP_BIT] == 1'b0 && sel[1:0] == 2'b11 && carry_in) |=>
      (result == $past(op_a) && carry_out));

  // R5: subtract with carry set reports no-borrow exactly when A >= B
  a_r5_borrow_flag: assert property (@(posedge clk) disable iff (rst)
    (sel[GROUP_BIT] == 1'b0 && sel[1:0] == 2'b10 && carry_in) |=>
      (carry_out == ($past(op_a) >= $past(op_b))));

endmodule

// File: tb/tb_alu_mode_top.sv
module tb_alu_mode_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a4 = '0, b4 = '0;
  logic [7:0] a8 = '0, b8 = '0;
  logic [3:0] s4 = '0, s8 = '0;
  logic       c4 = 1'b0, c8 = 1'b0;
  logic [3:0] r4;
  logic [7:0] r8;
  logic       co4, co8;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_mode_top #(.WIDTH(4)) dut (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .sel(s4),
    .carry_in(c4), .result(r4), .carry_out(co4)
  );

  alu_mode_top #(.WIDTH(8)) dut_w8 (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sel(s8),
    .carry_in(c8), .result(r8), .carry_out(co8)
  );

  // Reference model built from the requirements
  function automatic void ref_calc(input int w, input int a, input int b,
                                   input int s, input int cin,
                                   output int r, output int co);
    int mask;
    int arg;
    int sum;
    mask = (1 << w) - 1;
    if (s[3]) begin
      case (s & 3)
        0: r = a & b;
        1: r = a | b;
        2: r = a ^ b;
        default: r = (~a) & mask;
      endcase
      co = 0;
    end else begin
      case (s & 3)
        0: arg = 0;
        1: arg = b;
        2: arg = (~b) & mask;
        default: arg = mask;
      endcase
      sum = a + arg + cin;
      r  = sum & mask;
      co = (sum >> w) & 1;
    end
  endfunction

  function automatic string req_of(input int s);
    if (s[3]) return "R8";
    if (s[2]) return "R7";
    case (s & 3)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input int got_r, input int got_c,
                       input int exp_r, input int exp_c);
    checks++;
    if (got_r != exp_r || got_c != exp_c) begin
      errors++;
      $display("FAIL %s: result=%0h carry=%0d expected result=%0h carry=%0d",
               req, got_r, got_c, exp_r, exp_c);
    end
  endtask

  initial begin
    int er, ec;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", r4, co4, 0, 0);
    check("R1", r8, co8, 0, 0);
    rst = 1'b0;

    // R2..R8: exhaustive sweep of the 4-bit build, one cycle latency
    for (int s = 0; s < 16; s++)
      for (int cin = 0; cin < 2; cin++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            a4 = 4'(a); b4 = 4'(b); s4 = 4'(s); c4 = 1'(cin);
            @(negedge clk);
            ref_calc(4, a, b, s, cin, er, ec);
            check(req_of(s), int'(r4), int'(co4), er, ec);
          end

    // R9: 8-bit build over corner operand values, all codes
    for (int s = 0; s < 16; s++)
      for (int cin = 0; cin < 2; cin++)
        for (int ia = 0; ia < 8; ia++)
          for (int ib = 0; ib < 8; ib++) begin
            int vals[8] = '{0, 1, 8'h7f, 8'h80, 8'hfe, 8'hff, 8'h55, 8'haa};
            a8 = 8'(vals[ia]); b8 = 8'(vals[ib]); s8 = 4'(s); c8 = 1'(cin);
            @(negedge clk);
            ref_calc(8, vals[ia], vals[ib], s, cin, er, ec);
            check("R9", int'(r8), int'(co8), er, ec);
          end

    // R2: outputs change only one edge after the inputs
    a4 = 4'hf; b4 = 4'h1; s4 = 4'b0001; c4 = 1'b0;
    @(negedge clk);
    check("R2", r4, co4, 0, 1);
    a4 = 4'h3; b4 = 4'h4;
    #1;
    check("R2", r4, co4, 0, 1);
    @(negedge clk);
    check("R2", r4, co4, 7, 0);

    // R1: mid-run reset clears non-zero outputs
    a4 = 4'hf; s4 = 4'b0011; c4 = 1'b1;
    a8 = 8'hff; s8 = 4'b0011; c8 = 1'b1;
    @(negedge clk);
    check("R1", r4, co4, 15, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", r4, co4, 0, 0);
    check("R1", r8, co8, 0, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule